// File: doc/BRIEF.md
# Contiguous sprite slot allocator

The block tracks which of 64 hardware sprite slots are taken and hands out runs of adjacent free slots on request. An allocate request names a run length of one to four slots. The block searches for the lowest start index where that many consecutive slots are all free, marks the run as taken, and returns the start index. When no such run exists it returns a failure code and changes nothing. A free request names a start index and a run length, and clears those slots.

Requests use a valid/ready handshake. Each request gets exactly one response pulse, and that pulse carries a success flag and an index. The block accepts a new request only after it has answered the previous one. The occupancy mask and the number of taken slots are visible at all times. A sticky warning flag records any free request that covered a slot which was already free.

Top module: `slot_run_alloc`

## Requirements
- R1: After reset the mask is all zero, the in-use count is 0, the warning flag is 0, ready is 1 and no response is pending.
- R2: An allocate request with a count of 1 to 4 succeeds with the lowest start index p such that slots p to p+count-1 are all free. On success the response has ok=1 and index=p, and those bits become set.
- R3: Bit N of mask_o is 1 exactly when slot N is taken. used_o equals the number of set bits in mask_o.
- R4: When no run of the requested length is free, the response has ok=0 and index=127 (all ones, the -1 code), and the mask is unchanged.
- R5: A request of either kind with a count of 0 or a count of 5 to 7 is rejected with ok=0 and index=127. The mask and the warning flag are unchanged.
- R6: A free request with a valid count and start+count<=64 clears bits start to start+count-1. Its response has ok=1 and index=start. A free request with start+count>64 is rejected as in R4 and leaves the mask unchanged.
- R7: A valid free request whose range includes an already-free slot still clears the range and sets warn_o. warn_o stays 1 until reset.
- R8: A request is accepted only while req_ready_o is 1. Its single response pulse follows the accept edge by no more than 65 cycles. Ready is 0 while an allocate search is in progress.
- R9: A granted run never extends past slot 63. The search only tries start positions 0 to 64-count, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 1 | 0 = allocate, 1 = free |
| req_count_i | input | 3 | Run length |
| req_start_i | input | 6 | Start slot for a free request |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_ok_o | output | 1 | Request succeeded |
| rsp_index_o | output | 7 | Start slot, or 127 on failure |
| mask_o | output | 64 | Occupancy mask, bit N = slot N taken |
| used_o | output | 7 | Number of taken slots |
| warn_o | output | 1 | Sticky flag: a free request covered an already-free slot |

## Verification
For each run length, the first pattern fills an empty mask with runs of that length until the search fails. This checks that start indices climb in steps of the length and that the failure comes at the right point near slot 63. Freeing every other run and then asking for a longer run separates a correct first-fit search from one that accepts partial holes or skips early holes. The pattern also exercises the failure path that leaves the mask unchanged. Explicit cases for counts 0 and 5, a free past the top slot, and a double free separate the rejection paths from the warning path. A long pseudo-random mix of allocate and free requests is compared against an arithmetic first-fit model.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } slot_op_e;
endpackage

// File: rtl/slot_window_probe.sv
// Builds the run mask at a position and tests it against the occupancy mask.
module slot_window_probe #(
  parameter int NUM_SLOTS = 64,
  parameter int MAX_RUN   = 4,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter int CNT_W     = $clog2(MAX_RUN + 1)
) (
  input  logic [NUM_SLOTS-1:0] mask_i,
  input  logic [IDX_W-1:0]     pos_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [NUM_SLOTS-1:0] win_o,
  output logic                 clear_o,
  output logic                 full_o
);
  logic [NUM_SLOTS-1:0] base;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_base
    if (i < MAX_RUN) begin : g_run
      assign base[i] = (CNT_W'(i) < cnt_i);
    end else begin : g_zero
      assign base[i] = 1'b0;
    end
  end

  assign win_o   = base << pos_i;
  assign clear_o = ((mask_i & win_o) == '0);
  assign full_o  = ((mask_i & win_o) == win_o);
endmodule

// File: rtl/slot_popcount.sv
module slot_popcount #(
  parameter int NUM_SLOTS = 64,
  parameter int USED_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic [NUM_SLOTS-1:0] mask_i,
  output logic [USED_W-1:0]    used_o
);
  always_comb begin
    used_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) used_o = used_o + USED_W'(mask_i[i]);
  end
endmodule

// File: rtl/slot_run_alloc.sv
module slot_run_alloc
  import slot_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int MAX_RUN   = 4,
  parameter int MAX_LAT   = 65,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter int CNT_W     = $clog2(MAX_RUN + 1),
  parameter int USED_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_op_i,
  input  logic [CNT_W-1:0]     req_count_i,
  input  logic [IDX_W-1:0]     req_start_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_ok_o,
  output logic [IDX_W:0]       rsp_index_o,
  output logic [NUM_SLOTS-1:0] mask_o,
  output logic [USED_W-1:0]    used_o,
  output logic                 warn_o
);
  localparam logic [IDX_W:0] FAIL_IDX = '1;
  localparam int LAT_W = $clog2(MAX_LAT + 2);

  logic [NUM_SLOTS-1:0] mask_q;
  logic                 busy_q;
  logic [IDX_W-1:0]     pos_q;
  logic [CNT_W-1:0]     cnt_q;
  slot_op_e             op_q;
  logic                 rsp_valid_q, rsp_ok_q, warn_q;
  logic [IDX_W:0]       rsp_idx_q;
  logic [LAT_W-1:0]     lat_q;

  logic [IDX_W-1:0]     probe_pos;
  logic [CNT_W-1:0]     probe_cnt;
  logic [NUM_SLOTS-1:0] win;
  logic                 win_clear, win_full;
  logic                 accept, count_ok, free_range_ok, scan_last;
  slot_op_e             req_op;

  assign req_op    = slot_op_e'(req_op_i);
  assign probe_pos = busy_q ? pos_q : req_start_i;
  assign probe_cnt = busy_q ? cnt_q : req_count_i;

  slot_window_probe #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_RUN(MAX_RUN), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_probe (
    .mask_i (mask_q),
    .pos_i  (probe_pos),
    .cnt_i  (probe_cnt),
    .win_o  (win),
    .clear_o(win_clear),
    .full_o (win_full)
  );

  slot_popcount #(.NUM_SLOTS(NUM_SLOTS), .USED_W(USED_W)) u_pop (
    .mask_i(mask_q),
    .used_o(used_o)
  );

  assign accept        = req_valid_i && !busy_q;
  assign count_ok      = (req_count_i != '0) && (req_count_i <= CNT_W'(MAX_RUN));
  assign free_range_ok = (({1'b0, req_start_i} + (IDX_W+1)'(req_count_i))
                          <= (IDX_W+1)'(NUM_SLOTS));
  // last legal start position for the current run length
  assign scan_last     = ({1'b0, pos_q} == ((IDX_W+1)'(NUM_SLOTS) - (IDX_W+1)'(cnt_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '0;
      busy_q      <= 1'b0;
      pos_q       <= '0;
      cnt_q       <= '0;
      op_q        <= OP_ALLOC;
      rsp_valid_q <= 1'b0;
      rsp_ok_q    <= 1'b0;
      rsp_idx_q   <= FAIL_IDX;
      warn_q      <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        op_q  <= req_op;
        cnt_q <= req_count_i;
        pos_q <= '0;
        if (!count_ok || (req_op == OP_FREE && !free_range_ok)) begin
          rsp_valid_q <= 1'b1;
          rsp_ok_q    <= 1'b0;
          rsp_idx_q   <= FAIL_IDX;
        end else if (req_op == OP_FREE) begin
          mask_q      <= mask_q & ~win;
          if (!win_full) warn_q <= 1'b1;
          rsp_valid_q <= 1'b1;
          rsp_ok_q    <= 1'b1;
          rsp_idx_q   <= {1'b0, req_start_i};
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (win_clear) begin
          mask_q      <= mask_q | win;
          busy_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_ok_q    <= 1'b1;
          rsp_idx_q   <= {1'b0, pos_q};
        end else if (scan_last) begin
          busy_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_ok_q    <= 1'b0;
          rsp_idx_q   <= FAIL_IDX;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (!busy_q) lat_q <= '0;
    else              lat_q <= lat_q + 1'b1;
  end

  assign req_ready_o = !busy_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_ok_o    = rsp_ok_q;
  assign rsp_index_o = rsp_idx_q;
  assign mask_o      = mask_q;
  assign warn_o      = warn_q;

  // R4 / R5: a failed request leaves the mask alone
  a_r4_fail_keeps_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ok_o |-> mask_o == $past(mask_o));

  // R2: a granted run adds exactly count taken slots
  a_r2_alloc_adds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ok_o && op_q == OP_ALLOC |->
      used_o == $past(used_o) + USED_W'(cnt_q));

  // R9: no granted run passes the top slot
  a_r9_run_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ok_o |->
      (32'(rsp_index_o) + 32'(cnt_q)) <= NUM_SLOTS);

  // R8: a search never runs past the latency bound
  a_r8_latency_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> 32'(lat_q) < MAX_LAT);

  // R7: the warning flag is sticky
  a_r7_warn_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(warn_o));

  // R6: a successful free never raises the in-use count
  a_r6_free_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ok_o && op_q == OP_FREE |-> used_o <= $past(used_o));
endmodule

// File: tb/slot_run_alloc_tb.sv
module slot_run_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;
  localparam logic [6:0] FAIL = 7'h7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [2:0]  req_count = '0;
  logic [5:0]  req_start = '0;
  logic        rsp_valid, rsp_ok, warn;
  logic [6:0]  rsp_index, used;
  logic [63:0] mask;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] exp_mask = '0;
  logic        exp_warn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_run_alloc u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_count_i(req_count), .req_start_i(req_start),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .rsp_index_o(rsp_index),
    .mask_o(mask), .used_o(used), .warn_o(warn)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int first_fit(input logic [63:0] m, input int c);
    for (int p = 0; p <= NS - c; p++) begin
      bit ok = 1'b1;
      for (int i = 0; i < c; i++) if (m[p+i]) ok = 1'b0;
      if (ok) return p;
    end
    return -1;
  endfunction

  function automatic int ones(input logic [63:0] m);
    int n = 0;
    for (int i = 0; i < NS; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_mask = '0;
    exp_warn = 1'b0;
    @(negedge clk);
    check("R1", "mask", mask, 64'h0);
    check("R1", "used", 64'(used), 64'h0);
    check("R1", "warn", 64'(warn), 64'h0);
    check("R1", "ready", 64'(req_ready), 64'h1);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'h0);
  endtask

  task automatic do_op(input logic op, input int c, input int s);
    logic        e_ok;
    logic [6:0]  e_idx;
    logic [63:0] run;
    int          p;
    int          t;
    string       tag;
    bit          search;
    e_ok = 1'b0;
    e_idx = FAIL;
    search = 1'b0;
    run = '0;
    for (int i = 0; i < c && i < 4; i++) run[i] = 1'b1;
    if (c < 1 || c > 4) begin
      tag = "R5";
    end else if (op == 1'b0) begin
      p = first_fit(exp_mask, c);
      search = 1'b1;
      if (p >= 0) begin
        tag = "R2";
        e_ok = 1'b1;
        e_idx = 7'(p);
        exp_mask = exp_mask | (run << p);
      end else begin
        tag = "R4";
      end
    end else if (s + c > NS) begin
      tag = "R6";
    end else begin
      tag = ((exp_mask & (run << s)) != (run << s)) ? "R7" : "R6";
      if (tag == "R7") exp_warn = 1'b1;
      e_ok = 1'b1;
      e_idx = 7'(s);
      exp_mask = exp_mask & ~(run << s);
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op = op;
    req_count = 3'(c);
    req_start = 6'(s);
    @(negedge clk);
    req_valid = 1'b0;
    if (search) check("R8", "ready while searching", 64'(req_ready), 64'h0);
    t = 0;
    while (!rsp_valid && t < 80) begin
      @(negedge clk);
      t++;
    end
    check("R8", "latency within bound", 64'(t < 65), 64'h1);
    check(tag, "ok", 64'(rsp_ok), 64'(e_ok));
    check(tag, "index", 64'(rsp_index), 64'(e_idx));
    check(tag, "mask", mask, exp_mask);
    check("R3", "used", 64'(used), 64'(ones(exp_mask)));
    check("R7", "warn", 64'(warn), 64'(exp_warn));
    if (e_ok) check("R9", "run inside slots", 64'(int'(rsp_index) + c <= NS), 64'h1);
    @(negedge clk);
    check("R8", "single response pulse", 64'(rsp_valid), 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    // fill from empty with each run length, then fragment
    for (int c = 1; c <= 4; c++) begin
      do_reset();
      for (int k = 0; k <= NS / c; k++) do_op(1'b0, c, 0);
      for (int k = 0; k < NS / c; k += 2) do_op(1'b1, c, k * c);
      if (c < 4) do_op(1'b0, c + 1, 0);
      do_op(1'b0, c, 0);
      do_op(1'b0, 1, 0);
    end
    // edge-of-mask and rejection cases
    do_reset();
    for (int k = 0; k < 16; k++) do_op(1'b0, 4, 0);
    do_op(1'b1, 1, 63);
    do_op(1'b0, 2, 0);
    do_op(1'b0, 1, 0);
    do_op(1'b0, 0, 0);
    do_op(1'b0, 5, 0);
    do_op(1'b1, 0, 4);
    do_op(1'b1, 7, 4);
    do_op(1'b1, 4, 62);
    do_op(1'b1, 2, 10);
    do_op(1'b1, 3, 9);
    do_op(1'b0, 3, 0);
    do_op(1'b1, 4, 0);
    do_reset();
    // pseudo-random mix against the model
    for (int n = 0; n < 400; n++) begin
      int c;
      int s;
      logic op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[0] & lfsr[5];
      c = (lfsr[3:1] == 3'd7) ? 0 : (int'(lfsr[8:7]) + 1);
      if (lfsr[15:12] == 4'hF) c = 6;
      s = int'(lfsr[14:9]);
      do_op(op, c, s);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule